// File: doc/BRIEF.md
# Byte-Level GPIO Expander Register Core

This block holds the registers of an eight-pin expander whose pins behave as quasi-open-drain lines with pull-ups, and works out the level of each pin. A byte-level serial target front end, not part of this block, hands it three kinds of events: a transaction boundary (start or stop), a received byte, and a request for a byte to transmit. The core keeps four byte-wide registers: sampled input, output latch, polarity inversion and direction. A pointer byte selects among them.

In each transaction the first byte received after a boundary loads the pointer. Each later byte is written to the register the pointer selects, and the pointer never advances. A pin is pulled to 0 only when its direction bit and its output bit are both 0. Otherwise it follows the external level applied to it. The resolved levels form the input register and are also brought out on per-pin outputs.

Top module: `gpio_expander_core`

## Requirements
- R1: After reset the input and output registers read 0xFF, polarity reads 0x00, direction reads 0xFF, the pointer is 0 (so the first read returns the input register), and every pin output is 1.
- R2: The first byte received after a boundary event loads the pointer. Later bytes in the same transaction are written to the selected register, and the pointer does not increment, so a burst rewrites one register.
- R3: Only pointer bits [1:0] select the register: 0 is input, 1 is output latch, 2 is polarity, 3 is direction. Pointer bits [7:2] have no effect.
- R4: A read of register 0 returns the resolved input bits XORed with the polarity register. Reads of registers 1 to 3 return the stored value.
- R5: Pin i resolves to 0 when direction bit i and output bit i are both 0. Otherwise it resolves to the external level of pin i.
- R6: A byte written to register 0 changes no register and no pin.
- R7: A write to the polarity register leaves every pin output unchanged.
- R8: A write to the output or direction register, or a change of any external level, appears on all pin outputs on the clock edge that takes the write or the new level.
- R9: Read data is valid in the cycle the request is made and shows register contents from before that cycle's edge. It is 0 when no read is requested.
- R10: A byte arriving in the same cycle as a boundary event is taken as the pointer byte of the new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busEvent | input | 1 | Start or stop seen on the bus (one-cycle strobe) |
| byteValid | input | 1 | Received byte strobe |
| byteData | input | 8 | Received byte |
| readReq | input | 1 | Request for a byte to transmit |
| readData | output | 8 | Byte to transmit, valid while readReq is high |
| extLevel | input | 8 | External level on each pin |
| pinOut | output | 8 | Resolved level of each pin |

## Verification
Two pairs of functions can fall in the same cycle. A read request can arrive in the same cycle as a byte that writes the register being read. A boundary event can coincide with a received byte. The bench provokes the first by raising readReq together with byteValid. A correct result is the old register value, with the new value appearing from the next cycle. It provokes the second by pulsing busEvent together with byteValid in the middle of a write burst. A correct result is that the byte loads the pointer and writes nothing. A behavioural model checks both outcomes in every cycle, along with the resolved pins and the read data.

// File: rtl/gpio_exp_pkg.sv
package gpio_exp_pkg;
  parameter int DATA_W   = 8;
  parameter int REG_CNT  = 4;
  localparam int SEL_W   = $clog2(REG_CNT);

  typedef enum logic [SEL_W-1:0] {
    SEL_INPUT = 2'd0,
    SEL_OUT   = 2'd1,
    SEL_POL   = 2'd2,
    SEL_DIR   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              wrOut;
    logic              wrPol;
    logic              wrDir;
    logic [DATA_W-1:0] wrData;
  } ctrlStrobe_t;

  localparam logic [DATA_W-1:0] RST_OUT = '1;
  localparam logic [DATA_W-1:0] RST_POL = '0;
  localparam logic [DATA_W-1:0] RST_DIR = '1;
  localparam logic [DATA_W-1:0] RST_IN  = '1;
endpackage

// File: rtl/gpio_exp_ctrl.sv
module gpio_exp_ctrl
  import gpio_exp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEvent,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  output ctrlStrobe_t       strb,
  output logic [SEL_W-1:0]  ptrSel,
  output logic [DATA_W-1:0] ptrByte,
  output logic              haveAddr
);
  logic    isPtrByte;
  logic    isDataByte;
  regSel_e curSel;

  assign isPtrByte  = byteValid && (busEvent || !haveAddr);
  assign isDataByte = byteValid && !isPtrByte;
  assign curSel     = regSel_e'(ptrByte[SEL_W-1:0]);
  assign ptrSel     = ptrByte[SEL_W-1:0];

  always_comb begin
    strb        = '0;
    strb.wrData = byteData;
    if (isDataByte) begin
      unique case (curSel)
        SEL_OUT:   strb.wrOut = 1'b1;
        SEL_POL:   strb.wrPol = 1'b1;
        SEL_DIR:   strb.wrDir = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrByte  <= '0;
      haveAddr <= 1'b0;
    end else begin
      if (isPtrByte) ptrByte <= byteData;
      if (byteValid)     haveAddr <= 1'b1;
      else if (busEvent) haveAddr <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_exp_datapath.sv
module gpio_exp_datapath
  import gpio_exp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [SEL_W-1:0]  ptrSel,
  input  logic              readReq,
  input  logic [DATA_W-1:0] extLevel,
  output logic [DATA_W-1:0] readData,
  output logic [DATA_W-1:0] pinLevel
);
  logic [DATA_W-1:0] outReg, polReg, dirReg, inReg;
  logic [DATA_W-1:0] outNext, polNext, dirNext, inNext;

  assign outNext = strb.wrOut ? strb.wrData : outReg;
  assign polNext = strb.wrPol ? strb.wrData : polReg;
  assign dirNext = strb.wrDir ? strb.wrData : dirReg;

  for (genvar i = 0; i < DATA_W; i++) begin : g_pin
    logic released;
    assign released  = dirNext[i] | outNext[i];
    assign inNext[i] = released & extLevel[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg <= RST_OUT;
      polReg <= RST_POL;
      dirReg <= RST_DIR;
      inReg  <= RST_IN;
    end else begin
      outReg <= outNext;
      polReg <= polNext;
      dirReg <= dirNext;
      inReg  <= inNext;
    end
  end

  always_comb begin
    readData = '0;
    if (readReq) begin
      unique case (regSel_e'(ptrSel))
        SEL_INPUT: readData = inReg ^ polReg;
        SEL_OUT:   readData = outReg;
        SEL_POL:   readData = polReg;
        SEL_DIR:   readData = dirReg;
        default:   readData = '0;
      endcase
    end
  end

  assign pinLevel = inReg;
endmodule

// File: rtl/gpio_expander_core.sv
module gpio_expander_core
  import gpio_exp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEvent,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              readReq,
  output logic [DATA_W-1:0] readData,
  input  logic [DATA_W-1:0] extLevel,
  output logic [DATA_W-1:0] pinOut
);
  ctrlStrobe_t       strb;
  logic [SEL_W-1:0]  ptrSel;
  logic [DATA_W-1:0] ptrByte;
  logic              haveAddr;

  gpio_exp_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busEvent(busEvent), .byteValid(byteValid),
    .byteData(byteData), .strb(strb), .ptrSel(ptrSel), .ptrByte(ptrByte),
    .haveAddr(haveAddr)
  );

  gpio_exp_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .ptrSel(ptrSel), .readReq(readReq),
    .extLevel(extLevel), .readData(readData), .pinLevel(pinOut)
  );
endmodule

// File: rtl/gpio_expander_chk.sv
module gpio_expander_chk
  import gpio_exp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busEvent,
  input logic              byteValid,
  input logic              readReq,
  input logic [DATA_W-1:0] readData,
  input logic [DATA_W-1:0] extLevel,
  input logic [DATA_W-1:0] pinOut,
  input logic [DATA_W-1:0] ptrByte,
  input logic              haveAddr
);
  AST_RESET_PINS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (pinOut == '1)); // R1

  AST_PTR_HOLDS_IN_BURST: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && haveAddr && !busEvent) |=> $stable(ptrByte)); // R2

  AST_PIN_HIGH_NEEDS_EXT: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((pinOut & ~$past(extLevel)) == '0)); // R5

  AST_PINS_QUIET_NO_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !byteValid && (extLevel == $past(extLevel))) |=> $stable(pinOut)); // R8

  AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !readReq |-> (readData == '0)); // R9
endmodule

bind gpio_expander_core gpio_expander_chk chk_i (
  .clk(clk), .rstN(rstN), .busEvent(busEvent), .byteValid(byteValid),
  .readReq(readReq), .readData(readData), .extLevel(extLevel),
  .pinOut(pinOut), .ptrByte(ptrByte), .haveAddr(haveAddr)
);

// File: tb/gpio_expander_core_tb.sv
`timescale 1ns/1ps
module gpio_expander_core_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busEvent = 1'b0, byteValid = 1'b0, readReq = 1'b0;
  logic [7:0] byteData = '0, extLevel = 8'hFF;
  logic [7:0] readData, pinOut;

  always #2.5 clk = ~clk;

  gpio_expander_core dut_i (
    .clk(clk), .rstN(rstN), .busEvent(busEvent), .byteValid(byteValid),
    .byteData(byteData), .readReq(readReq), .readData(readData),
    .extLevel(extLevel), .pinOut(pinOut)
  );

  int checks = 0, fails = 0;
  string curReq = "R1";
  int mRegs[4];
  int mPtr, mHave;
  logic [7:0] mIn;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] modelRead();
    int s = mPtr % 4;
    if (!readReq) return 8'h00;
    if (s == 0) return 8'(mIn ^ 8'(mRegs[2]));
    return 8'(mRegs[s]);
  endfunction

  task automatic modelReset();
    mRegs[0] = 255; mRegs[1] = 255; mRegs[2] = 0; mRegs[3] = 255;
    mPtr = 0; mHave = 0; mIn = 8'hFF;
  endtask

  task automatic modelEdge();
    if (byteValid) begin
      if (busEvent || mHave == 0) begin
        mPtr = int'(byteData); mHave = 1;
      end else if (mPtr % 4 != 0) begin
        mRegs[mPtr % 4] = int'(byteData);
      end
    end else if (busEvent) mHave = 0;
    mIn = 8'(mRegs[3] | mRegs[1]) & extLevel;
  endtask

  // one cycle: inputs held since last negedge
  task automatic cycle(input logic ev, input logic bv, input logic [7:0] d,
                       input logic rr, input logic [7:0] ext);
    busEvent = ev; byteValid = bv; byteData = d; readReq = rr; extLevel = ext;
    #1;
    check((rr && bv) ? "R9" : curReq, readData, modelRead());
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(curReq, pinOut, mIn);
    busEvent = 0; byteValid = 0; readReq = 0;
  endtask

  task automatic wrReg(input logic [7:0] p, input logic [7:0] v);
    cycle(1, 0, 0, 0, extLevel);
    cycle(0, 1, p, 0, extLevel);
    cycle(0, 1, v, 0, extLevel);
  endtask

  task automatic rdReg(input logic [7:0] p, output logic [7:0] v);
    cycle(1, 0, 0, 0, extLevel);
    cycle(0, 1, p, 0, extLevel);
    cycle(1, 0, 0, 0, extLevel);
    busEvent = 0; readReq = 1; #1; v = readData;
    cycle(0, 0, 0, 1, extLevel);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curReq = "R1";
    check("R1", pinOut, 8'hFF);
    readReq = 1; #1; check("R1", readData, 8'hFF); readReq = 0;
    rdReg(8'd1, v); check("R1", v, 8'hFF);
    rdReg(8'd2, v); check("R1", v, 8'h00);
    rdReg(8'd3, v); check("R1", v, 8'hFF);

    curReq = "R5";
    wrReg(8'd1, 8'h0F);          // latch low nibble high, still inputs
    check("R5", pinOut, 8'hFF);
    wrReg(8'd3, 8'h00);          // all outputs
    check("R5", pinOut, 8'h0F);
    cycle(0, 0, 0, 0, 8'h3C);
    check("R5", pinOut, 8'h0C);

    curReq = "R8";
    cycle(0, 0, 0, 0, 8'hFF);
    check("R8", pinOut, 8'h0F);
    wrReg(8'd3, 8'hA0);
    check("R8", pinOut, 8'hAF);

    curReq = "R4";
    wrReg(8'd2, 8'hFF);
    rdReg(8'd0, v); check("R4", v, 8'h50);

    curReq = "R7";
    check("R7", pinOut, 8'hAF);
    wrReg(8'd2, 8'h33);
    check("R7", pinOut, 8'hAF);

    curReq = "R6";
    wrReg(8'd0, 8'h00);
    check("R6", pinOut, 8'hAF);
    rdReg(8'd0, v); check("R6", v, 8'hAF ^ 8'h33);

    curReq = "R3";
    wrReg(8'hFD, 8'h55);         // upper pointer bits ignored -> output
    rdReg(8'd1, v); check("R3", v, 8'h55);

    curReq = "R2";
    cycle(1, 0, 0, 0, extLevel);
    cycle(0, 1, 8'd1, 0, extLevel);
    cycle(0, 1, 8'h11, 0, extLevel);
    cycle(0, 1, 8'h22, 0, extLevel);
    cycle(0, 1, 8'h44, 0, extLevel);
    rdReg(8'd1, v); check("R2", v, 8'h44);
    rdReg(8'd3, v); check("R2", v, 8'hA0);

    curReq = "R9";
    cycle(1, 0, 0, 0, extLevel);
    cycle(0, 1, 8'd1, 0, extLevel);
    busEvent = 0; byteValid = 1; byteData = 8'h99; readReq = 1; #1;
    check("R9", readData, 8'h44);
    cycle(0, 1, 8'h99, 1, extLevel);
    readReq = 1; #1; check("R9", readData, 8'h99); readReq = 0;

    curReq = "R10";
    cycle(0, 1, 8'h77, 0, extLevel);      // still writes output
    cycle(1, 1, 8'd2, 0, extLevel);       // event + byte: pointer load
    cycle(0, 1, 8'h0A, 0, extLevel);      // goes to polarity
    rdReg(8'd1, v); check("R10", v, 8'h77);
    rdReg(8'd2, v); check("R10", v, 8'h0A);

    for (int k = 0; k < 40; k++) begin
      curReq = "R8";
      cycle(k % 5 == 0, k % 3 == 0, 8'(k * 37), k % 2 == 1, 8'(k * 91));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule